// File: doc/BRIEF.md
# Per-Channel Handshake Buffer for a Five-Channel Link

This block sits in the middle of a five-channel valid/ready link of the AXI4 kind. Three channels carry requests from the upstream side to the downstream side: write address, write data and read address. Two channels carry responses back: write response and read data. Each channel passes through its own small queue, and each queue is configured separately. The block stores and forwards payloads as opaque bit vectors and never looks inside them.

Each queue has three settings: an entry count, a flow option and a pipe option. With the flow option, an item that reaches an empty queue is offered at the output in the same cycle. With the pipe option, a full queue still accepts input when its output is being drained in the same cycle, so one entry is enough for one transfer per cycle. An entry count of zero removes the storage, and the channel becomes a direct connection.

A mode parameter selects how settings reach the channels. The first mode gives one setting to all five channels. The second gives one setting to the request group and one to the response group. The third gives each channel its own setting. The package provides four presets: default, none, flow and pipe. It also provides a helper that turns a bare entry count into a setting with both options off.

Top module: `hsbuf_link`

## Requirements
- R1: On every channel, items leave in the order they were accepted, with none lost or repeated, under any pattern of input valid and output ready.
- R2: A channel with entry count 0 is a direct connection. Output valid and payload follow the input in the same cycle, and input ready follows output ready in the same cycle.
- R3: A channel with entry count N and the flow option off raises output valid no earlier than the cycle after an item is accepted. While its output is stalled, it accepts exactly N items and then holds input ready low.
- R4: A channel with the flow option set, when empty, offers an arriving item at its output in the same cycle as the item arrives.
- R5: A channel with the pipe option set keeps input ready high whenever its output completes a transfer, even when full. A single-entry pipe queue therefore sustains one transfer per cycle.
- R6: While output valid is high and output ready is low, a queued channel keeps output valid high and the payload unchanged in the next cycle.
- R7: Channel setting selection works as follows. Mode CFG_ALL applies CFG_ALL_Q to every channel. Mode CFG_BY_DIR applies CFG_REQ_Q to the write-address, write-data and read-address channels, and CFG_RSP_Q to the write-response and read-data channels. Mode CFG_PER_CH applies one setting per channel. The default setting is 2 entries with both options off. The flow preset is 1 entry with flow on. The pipe preset is 1 entry with pipe on.
- R8: While rst_ni is low, every queue is empty and every queued channel drives output valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_aw_valid_i | input | 1 | Write address valid from upstream |
| up_aw_ready_o | output | 1 | Write address ready to upstream |
| up_aw_data_i | input | AW_W | Write address payload from upstream |
| dn_aw_valid_o | output | 1 | Write address valid to downstream |
| dn_aw_ready_i | input | 1 | Write address ready from downstream |
| dn_aw_data_o | output | AW_W | Write address payload to downstream |
| up_w_valid_i | input | 1 | Write data valid from upstream |
| up_w_ready_o | output | 1 | Write data ready to upstream |
| up_w_data_i | input | W_W | Write data payload from upstream |
| dn_w_valid_o | output | 1 | Write data valid to downstream |
| dn_w_ready_i | input | 1 | Write data ready from downstream |
| dn_w_data_o | output | W_W | Write data payload to downstream |
| dn_b_valid_i | input | 1 | Write response valid from downstream |
| dn_b_ready_o | output | 1 | Write response ready to downstream |
| dn_b_data_i | input | B_W | Write response payload from downstream |
| up_b_valid_o | output | 1 | Write response valid to upstream |
| up_b_ready_i | input | 1 | Write response ready from upstream |
| up_b_data_o | output | B_W | Write response payload to upstream |
| up_ar_valid_i | input | 1 | Read address valid from upstream |
| up_ar_ready_o | output | 1 | Read address ready to upstream |
| up_ar_data_i | input | AR_W | Read address payload from upstream |
| dn_ar_valid_o | output | 1 | Read address valid to downstream |
| dn_ar_ready_i | input | 1 | Read address ready from downstream |
| dn_ar_data_o | output | AR_W | Read address payload to downstream |
| dn_r_valid_i | input | 1 | Read data valid from downstream |
| dn_r_ready_o | output | 1 | Read data ready to downstream |
| dn_r_data_i | input | R_W | Read data payload from downstream |
| up_r_valid_o | output | 1 | Read data valid to upstream |
| up_r_ready_i | input | 1 | Read data ready from upstream |
| up_r_data_o | output | R_W | Read data payload to upstream |

## Verification
The assertions check four properties on every cycle of every queued channel:
- a stalled output stays valid with the same payload;
- a full queue without the pipe option refuses input while its output is blocked;
- a pipe queue accepts input whenever its output transfers;
- a flow queue presents its input as soon as that input is valid.

Only the bench scenarios can show end-to-end ordering and loss-free transfer on each channel, and the exact capacity of each queue depth. The same holds for the transparency of a zero-entry channel and for setting selection in the per-channel and per-direction modes. For these, the bench compares the output items against a scoreboard and probes each channel's handshake in directed cycles.

// File: rtl/hsbuf_pkg.sv
package hsbuf_pkg;

  typedef struct packed {
    logic [7:0] depth;
    logic       flow;
    logic       pipe;
  } qcfg_t;

  typedef enum logic [1:0] {CFG_ALL, CFG_BY_DIR, CFG_PER_CH} cfg_mode_e;

  localparam qcfg_t QCFG_DEFAULT = '{depth: 8'd2, flow: 1'b0, pipe: 1'b0};
  localparam qcfg_t QCFG_NONE    = '{depth: 8'd0, flow: 1'b0, pipe: 1'b0};
  localparam qcfg_t QCFG_FLOW    = '{depth: 8'd1, flow: 1'b1, pipe: 1'b0};
  localparam qcfg_t QCFG_PIPE    = '{depth: 8'd1, flow: 1'b0, pipe: 1'b1};

  // bare entry count -> setting with both options off
  function automatic qcfg_t qcfg_depth(int unsigned d);
    qcfg_t c;
    c.depth = d[7:0];
    c.flow  = 1'b0;
    c.pipe  = 1'b0;
    return c;
  endfunction

  function automatic qcfg_t qcfg_pick(cfg_mode_e mode, qcfg_t all_q, qcfg_t grp_q, qcfg_t own_q);
    case (mode)
      CFG_ALL:    return all_q;
      CFG_BY_DIR: return grp_q;
      default:    return own_q;
    endcase
  endfunction

endpackage

// File: rtl/hsbuf_chan.sv
module hsbuf_chan #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2,
  parameter bit          FLOW  = 1'b0,
  parameter bit          PIPE  = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  if (DEPTH == 0) begin : g_wire
    assign out_valid_o = in_valid_i;
    assign out_data_o  = in_data_i;
    assign in_ready_o  = out_ready_i;
  end else begin : g_q
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          empty, full, bypass, push, pop;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CW'(DEPTH));
    // flow: item skips storage when it can leave right away
    assign bypass = FLOW && empty && in_valid_i && out_ready_i;

    assign out_valid_o = !empty || (FLOW && in_valid_i);
    assign out_data_o  = (FLOW && empty) ? in_data_i : mem_q[rd_q];
    // pipe: a same-cycle dequeue frees a slot for the incoming item
    assign in_ready_o  = !full || (PIPE && out_ready_i);

    assign push = in_valid_i && in_ready_o && !bypass;
    assign pop  = out_valid_o && out_ready_i && !empty;

    always_ff @(posedge clk_i) begin
      if (push) mem_q[wr_q] <= in_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q  <= '0;
        rd_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        case ({push, pop})
          2'b10:   cnt_q <= cnt_q + 1'b1;
          2'b01:   cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end

    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full && !out_ready_i |-> !in_ready_o);

    if (PIPE) begin : g_pipe_chk
      p_pipe_rate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o && out_ready_i |-> in_ready_o);
    end

    if (FLOW) begin : g_flow_chk
      p_flow_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |-> out_valid_o);
    end
  end

endmodule

// File: rtl/hsbuf_link.sv
module hsbuf_link
  import hsbuf_pkg::*;
#(
  parameter int unsigned AW_W     = 32,
  parameter int unsigned W_W      = 32,
  parameter int unsigned B_W      = 8,
  parameter int unsigned AR_W     = 32,
  parameter int unsigned R_W      = 40,
  parameter cfg_mode_e   MODE     = CFG_ALL,
  parameter qcfg_t       CFG_ALL_Q = QCFG_DEFAULT,
  parameter qcfg_t       CFG_REQ_Q = QCFG_DEFAULT,
  parameter qcfg_t       CFG_RSP_Q = QCFG_DEFAULT,
  parameter qcfg_t       CFG_AW_Q  = QCFG_DEFAULT,
  parameter qcfg_t       CFG_W_Q   = QCFG_DEFAULT,
  parameter qcfg_t       CFG_B_Q   = QCFG_DEFAULT,
  parameter qcfg_t       CFG_AR_Q  = QCFG_DEFAULT,
  parameter qcfg_t       CFG_R_Q   = QCFG_DEFAULT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            up_aw_valid_i,
  output logic            up_aw_ready_o,
  input  logic [AW_W-1:0] up_aw_data_i,
  output logic            dn_aw_valid_o,
  input  logic            dn_aw_ready_i,
  output logic [AW_W-1:0] dn_aw_data_o,
  input  logic            up_w_valid_i,
  output logic            up_w_ready_o,
  input  logic [W_W-1:0]  up_w_data_i,
  output logic            dn_w_valid_o,
  input  logic            dn_w_ready_i,
  output logic [W_W-1:0]  dn_w_data_o,
  input  logic            dn_b_valid_i,
  output logic            dn_b_ready_o,
  input  logic [B_W-1:0]  dn_b_data_i,
  output logic            up_b_valid_o,
  input  logic            up_b_ready_i,
  output logic [B_W-1:0]  up_b_data_o,
  input  logic            up_ar_valid_i,
  output logic            up_ar_ready_o,
  input  logic [AR_W-1:0] up_ar_data_i,
  output logic            dn_ar_valid_o,
  input  logic            dn_ar_ready_i,
  output logic [AR_W-1:0] dn_ar_data_o,
  input  logic            dn_r_valid_i,
  output logic            dn_r_ready_o,
  input  logic [R_W-1:0]  dn_r_data_i,
  output logic            up_r_valid_o,
  input  logic            up_r_ready_i,
  output logic [R_W-1:0]  up_r_data_o
);

  localparam qcfg_t AW_C = qcfg_pick(MODE, CFG_ALL_Q, CFG_REQ_Q, CFG_AW_Q);
  localparam qcfg_t W_C  = qcfg_pick(MODE, CFG_ALL_Q, CFG_REQ_Q, CFG_W_Q);
  localparam qcfg_t AR_C = qcfg_pick(MODE, CFG_ALL_Q, CFG_REQ_Q, CFG_AR_Q);
  localparam qcfg_t B_C  = qcfg_pick(MODE, CFG_ALL_Q, CFG_RSP_Q, CFG_B_Q);
  localparam qcfg_t R_C  = qcfg_pick(MODE, CFG_ALL_Q, CFG_RSP_Q, CFG_R_Q);

  hsbuf_chan #(.W(AW_W), .DEPTH(int'(AW_C.depth)), .FLOW(AW_C.flow), .PIPE(AW_C.pipe)) u_aw (
    .clk_i, .rst_ni,
    .in_valid_i(up_aw_valid_i), .in_ready_o(up_aw_ready_o), .in_data_i(up_aw_data_i),
    .out_valid_o(dn_aw_valid_o), .out_ready_i(dn_aw_ready_i), .out_data_o(dn_aw_data_o));

  hsbuf_chan #(.W(W_W), .DEPTH(int'(W_C.depth)), .FLOW(W_C.flow), .PIPE(W_C.pipe)) u_w (
    .clk_i, .rst_ni,
    .in_valid_i(up_w_valid_i), .in_ready_o(up_w_ready_o), .in_data_i(up_w_data_i),
    .out_valid_o(dn_w_valid_o), .out_ready_i(dn_w_ready_i), .out_data_o(dn_w_data_o));

  hsbuf_chan #(.W(B_W), .DEPTH(int'(B_C.depth)), .FLOW(B_C.flow), .PIPE(B_C.pipe)) u_b (
    .clk_i, .rst_ni,
    .in_valid_i(dn_b_valid_i), .in_ready_o(dn_b_ready_o), .in_data_i(dn_b_data_i),
    .out_valid_o(up_b_valid_o), .out_ready_i(up_b_ready_i), .out_data_o(up_b_data_o));

  hsbuf_chan #(.W(AR_W), .DEPTH(int'(AR_C.depth)), .FLOW(AR_C.flow), .PIPE(AR_C.pipe)) u_ar (
    .clk_i, .rst_ni,
    .in_valid_i(up_ar_valid_i), .in_ready_o(up_ar_ready_o), .in_data_i(up_ar_data_i),
    .out_valid_o(dn_ar_valid_o), .out_ready_i(dn_ar_ready_i), .out_data_o(dn_ar_data_o));

  hsbuf_chan #(.W(R_W), .DEPTH(int'(R_C.depth)), .FLOW(R_C.flow), .PIPE(R_C.pipe)) u_r (
    .clk_i, .rst_ni,
    .in_valid_i(dn_r_valid_i), .in_ready_o(dn_r_ready_o), .in_data_i(dn_r_data_i),
    .out_valid_o(up_r_valid_o), .out_ready_i(up_r_ready_i), .out_data_o(up_r_data_o));

endmodule

// File: tb/hsbuf_link_bench.sv
module hsbuf_link_bench;
  import hsbuf_pkg::*;

  // channel index: 0 aw, 1 w, 2 b, 3 ar, 4 r
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        in_v [5], out_r [5], in_r [5], out_v [5];
  logic [15:0] in_d [5], out_d [5];
  logic        din_v [5], dout_r [5], din_r [5], dout_v [5];
  logic [15:0] din_d [5], dout_d [5];

  int checks = 0, errors = 0;
  logic [15:0] sb [5][$];
  logic [15:0] seq [5];
  bit done = 1'b0;

  // per-channel: aw wire, w flow, b pipe, ar default, r bare depth 3
  hsbuf_link #(.AW_W(16), .W_W(16), .B_W(16), .AR_W(16), .R_W(16), .MODE(CFG_PER_CH),
    .CFG_AW_Q(QCFG_NONE), .CFG_W_Q(QCFG_FLOW), .CFG_B_Q(QCFG_PIPE),
    .CFG_AR_Q(QCFG_DEFAULT), .CFG_R_Q(qcfg_depth(3))) u_hsbuf_link (
    .clk_i(clk), .rst_ni,
    .up_aw_valid_i(in_v[0]), .up_aw_ready_o(in_r[0]), .up_aw_data_i(in_d[0]),
    .dn_aw_valid_o(out_v[0]), .dn_aw_ready_i(out_r[0]), .dn_aw_data_o(out_d[0]),
    .up_w_valid_i(in_v[1]), .up_w_ready_o(in_r[1]), .up_w_data_i(in_d[1]),
    .dn_w_valid_o(out_v[1]), .dn_w_ready_i(out_r[1]), .dn_w_data_o(out_d[1]),
    .dn_b_valid_i(in_v[2]), .dn_b_ready_o(in_r[2]), .dn_b_data_i(in_d[2]),
    .up_b_valid_o(out_v[2]), .up_b_ready_i(out_r[2]), .up_b_data_o(out_d[2]),
    .up_ar_valid_i(in_v[3]), .up_ar_ready_o(in_r[3]), .up_ar_data_i(in_d[3]),
    .dn_ar_valid_o(out_v[3]), .dn_ar_ready_i(out_r[3]), .dn_ar_data_o(out_d[3]),
    .dn_r_valid_i(in_v[4]), .dn_r_ready_o(in_r[4]), .dn_r_data_i(in_d[4]),
    .up_r_valid_o(out_v[4]), .up_r_ready_i(out_r[4]), .up_r_data_o(out_d[4]));

  // by-direction: requests flow preset, responses wire
  hsbuf_link #(.AW_W(16), .W_W(16), .B_W(16), .AR_W(16), .R_W(16), .MODE(CFG_BY_DIR),
    .CFG_REQ_Q(QCFG_FLOW), .CFG_RSP_Q(QCFG_NONE)) u_hsbuf_link_dir (
    .clk_i(clk), .rst_ni,
    .up_aw_valid_i(din_v[0]), .up_aw_ready_o(din_r[0]), .up_aw_data_i(din_d[0]),
    .dn_aw_valid_o(dout_v[0]), .dn_aw_ready_i(dout_r[0]), .dn_aw_data_o(dout_d[0]),
    .up_w_valid_i(din_v[1]), .up_w_ready_o(din_r[1]), .up_w_data_i(din_d[1]),
    .dn_w_valid_o(dout_v[1]), .dn_w_ready_i(dout_r[1]), .dn_w_data_o(dout_d[1]),
    .dn_b_valid_i(din_v[2]), .dn_b_ready_o(din_r[2]), .dn_b_data_i(din_d[2]),
    .up_b_valid_o(dout_v[2]), .up_b_ready_i(dout_r[2]), .up_b_data_o(dout_d[2]),
    .up_ar_valid_i(din_v[3]), .up_ar_ready_o(din_r[3]), .up_ar_data_i(din_d[3]),
    .dn_ar_valid_o(dout_v[3]), .dn_ar_ready_i(dout_r[3]), .dn_ar_data_o(dout_d[3]),
    .dn_r_valid_i(din_v[4]), .dn_r_ready_o(din_r[4]), .dn_r_data_i(din_d[4]),
    .up_r_valid_o(dout_v[4]), .up_r_ready_i(dout_r[4]), .up_r_data_o(dout_d[4]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard step: sample handshakes after inputs settle, then advance one cycle
  task automatic step();
    #1;
    for (int c = 0; c < 5; c++) begin
      if (in_v[c] && in_r[c]) sb[c].push_back(in_d[c]);
      if (out_v[c] && out_r[c]) begin
        if (sb[c].size() == 0) chk(1'b0, "R1 unexpected item", int'(out_d[c]), 0);
        else begin
          logic [15:0] e;
          e = sb[c].pop_front();
          chk(out_d[c] == e, "R1 order", int'(out_d[c]), int'(e));
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_all();
    for (int c = 0; c < 5; c++) begin
      in_v[c] = 1'b0; out_r[c] = 1'b0; in_d[c] = '0;
      din_v[c] = 1'b0; dout_r[c] = 1'b0; din_d[c] = '0;
    end
  endtask

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    #1;
    for (int c = 0; c < 5; c++) chk(out_v[c] == 1'b0, "R8 reset valid low", int'(out_v[c]), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: zero-entry channel is a wire
    in_v[0] = 1'b1; in_d[0] = 16'h1111; #1;
    chk(out_v[0] == 1'b1 && out_d[0] == 16'h1111, "R2 same-cycle pass", int'(out_d[0]), 16'h1111);
    chk(in_r[0] == 1'b0, "R2 ready follows stall", int'(in_r[0]), 0);
    out_r[0] = 1'b1; #1;
    chk(in_r[0] == 1'b1, "R2 ready follows", int'(in_r[0]), 1);
    step(); in_v[0] = 1'b0; out_r[0] = 1'b0;

    // R4/R6: flow channel
    in_v[1] = 1'b1; in_d[1] = 16'h2222; #1;
    chk(out_v[1] == 1'b1 && out_d[1] == 16'h2222, "R4 flow same cycle", int'(out_d[1]), 16'h2222);
    step(); in_v[1] = 1'b0; in_d[1] = 16'h0; #1;
    chk(out_v[1] == 1'b1 && out_d[1] == 16'h2222, "R6 held while stalled", int'(out_d[1]), 16'h2222);
    step(); #1;
    chk(out_v[1] == 1'b1 && out_d[1] == 16'h2222, "R6 still held", int'(out_d[1]), 16'h2222);
    out_r[1] = 1'b1; step(); out_r[1] = 1'b0; #1;
    chk(out_v[1] == 1'b0, "R4 drained", int'(out_v[1]), 0);

    // R3: default setting holds exactly 2
    in_v[3] = 1'b1; in_d[3] = 16'h3301; #1;
    chk(out_v[3] == 1'b0, "R3 no same-cycle output", int'(out_v[3]), 0);
    step(); #1;
    chk(out_v[3] == 1'b1 && out_d[3] == 16'h3301, "R3 output next cycle", int'(out_d[3]), 16'h3301);
    in_d[3] = 16'h3302; step(); in_d[3] = 16'h3303; #1;
    chk(in_r[3] == 1'b0, "R3 full after 2 (R7 default depth)", int'(in_r[3]), 0);
    in_v[3] = 1'b0; out_r[3] = 1'b1; step(); step(); out_r[3] = 1'b0;

    // R3: bare depth 3 holds exactly 3
    in_v[4] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      in_d[4] = 16'h4400 + 16'(k); #1;
      chk(in_r[4] == 1'b1, "R3 accepts up to 3", int'(in_r[4]), 1);
      step();
    end
    #1; chk(in_r[4] == 1'b0, "R3 full after 3", int'(in_r[4]), 0);
    in_v[4] = 1'b0; out_r[4] = 1'b1; repeat (3) step(); out_r[4] = 1'b0;

    // R5: pipe single entry at full rate
    in_v[2] = 1'b1; in_d[2] = 16'h5500; step(); #1;
    chk(in_r[2] == 1'b0, "R5 full and stalled", int'(in_r[2]), 0);
    out_r[2] = 1'b1;
    for (int k = 1; k < 6; k++) begin
      in_d[2] = 16'h5500 + 16'(k); #1;
      chk(in_r[2] == 1'b1 && out_v[2] == 1'b1, "R5 one per cycle", int'(in_r[2]), 1);
      step();
    end
    in_v[2] = 1'b0; step(); out_r[2] = 1'b0;

    // R7: by-direction instance
    din_v[0] = 1'b1; din_d[0] = 16'h0A0A; din_v[3] = 1'b1; din_d[3] = 16'h0B0B;
    din_v[2] = 1'b1; din_d[2] = 16'h0C0C; #1;
    chk(dout_v[0] == 1'b1 && dout_d[0] == 16'h0A0A, "R7 req group flow aw", int'(dout_d[0]), 16'h0A0A);
    chk(dout_v[3] == 1'b1 && dout_d[3] == 16'h0B0B, "R7 req group flow ar", int'(dout_d[3]), 16'h0B0B);
    chk(din_r[2] == 1'b0 && dout_v[2] == 1'b1, "R7 rsp group wire", int'(din_r[2]), 0);
    dout_r[2] = 1'b1; #1;
    chk(din_r[2] == 1'b1, "R7 rsp group ready passes", int'(din_r[2]), 1);
    step();
    for (int c = 0; c < 5; c++) begin din_v[c] = 1'b0; dout_r[c] = 1'b0; end

    // R1: random stalls on all channels
    for (int c = 0; c < 5; c++) seq[c] = 16'(c) << 12;
    for (int n = 0; n < 3000; n++) begin
      for (int c = 0; c < 5; c++) begin
        in_v[c]  = ($urandom % 3) != 0;
        out_r[c] = ($urandom % 3) != 0;
        in_d[c]  = seq[c];
      end
      #1;
      for (int c = 0; c < 5; c++) if (in_v[c] && in_r[c]) seq[c] = seq[c] + 1'b1;
      step();
    end
    for (int c = 0; c < 5; c++) begin in_v[c] = 1'b0; out_r[c] = 1'b1; end
    repeat (8) step();
    for (int c = 0; c < 5; c++) chk(sb[c].size() == 0, "R1 nothing lost", sb[c].size(), 0);

    // R8: reset empties queued channels
    in_v[4] = 1'b1; out_r[4] = 1'b0; step(); in_v[4] = 1'b0;
    rst_ni = 1'b0; #1;
    chk(out_v[4] == 1'b0, "R8 reset clears", int'(out_v[4]), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule